// File: doc/BRIEF.md
# Ping-Pong Stream Page Address Engine

This block generates the host-memory addresses for one direction of a synchronous audio/data stream that runs between the network transceiver's frame slots and host memory. Software gives it a base address and a page length in bytes. The block splits the region into two back-to-back pages. Page 0 starts at the base address, and page 1 starts at the base plus the page length. Each quadlet that moves advances the address by four bytes inside the current page. When the last quadlet of a page completes, the engine wraps to the start of the other page, toggles a page pointer that software can read, and emits a one-cycle page-change event for the interrupt logic. Software refills or drains the page that hardware is not currently using.

The parameter `IS_RX` picks the direction at elaboration time. A receive instance takes quadlets from the slot side and writes them to memory. A transmit instance reads quadlets from memory and hands them to the slot side. Both directions can reverse the byte order of each quadlet for big-endian hosts. The memory side is a plain request/grant word port: a request is accepted in the cycle in which the grant is high, and read data are valid in that same cycle.

Top module: `sync_page_engine`

## Requirements
- R1: After synchronous reset, all three registers read zero, no memory request is raised and the page-change event is low.
- R2: The transmit instance decodes base at 0x20, length at 0x24 and control at 0x28, with run in control bit 1 and page pointer in bit 0. The receive instance decodes 0x30, 0x34 and 0x38, with run in bit 3 and pointer in bit 2. Address bits 1:0 of base and length always read 0. Other offsets read 0. Writes to the pointer bit are ignored.
- R3: Writing run=1 while stopped sets the pointer to page 0, and the next transfer targets the base address.
- R4: Every request carries the address base + (pointer ? length : 0) + offset. Each accepted transfer adds 4 to the offset.
- R5: A transfer for which offset+4 >= length ends the page. The offset returns to 0, the pointer toggles, and the page-change event is high for exactly the following cycle.
- R6: While run=0 no memory request is raised and the pointer holds its value.
- R7: Receive: request = run AND slot-valid, it is a write, and slot-ready = request AND grant. Transmit: request = run AND slot-ready, it is a read, and slot-valid = request AND grant.
- R8: With big_endian=1, byte lane i (bits 8i+7:8i) of the data moves to lane 3-i. With big_endian=0, data pass through unchanged.
- R9: A control write that clears run in the same cycle as an accepted transfer still counts that transfer. This includes a page change and its event.
- R10: Writing run=1 while already running leaves the pointer and offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, shared by write and read |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| big_endian | input | 1 | Reverse the byte order of each quadlet |
| strm_valid_i | input | 1 | Slot side has a quadlet (receive) |
| strm_data_i | input | DW | Slot-side quadlet in (receive) |
| strm_ready_o | output | 1 | Quadlet taken (receive) |
| strm_valid_o | output | 1 | Quadlet delivered (transmit) |
| strm_data_o | output | DW | Slot-side quadlet out (transmit) |
| strm_ready_i | input | 1 | Slot side wants a quadlet (transmit) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the quadlet |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Read data, valid with the grant |
| page_evt | output | 1 | One-cycle page-change event |

## Verification
Two events can land on the same edge: a software write to the control register, and a granted transfer that may also close a page. The bench provokes this collision in three ways. It stops the engine on a cycle that carries a transfer, using page lengths that include single-quadlet pages so that the collision often ends a page. It also re-writes run=1, with the pointer bit set, in the middle of a stream. A bench model applies the transfer first and the register write second. Against that model the bench judges the pointer readback, the event pulse and the address of the following request.

// File: rtl/sp_pkg.sv
package sp_pkg;

    // Offsets of the three registers within the instance's window.
    localparam logic [7:0] OFS_BASE = 8'h00;
    localparam logic [7:0] OFS_LEN  = 8'h04;
    localparam logic [7:0] OFS_CTL  = 8'h08;

    // Control register as seen by the datapath.
    typedef struct packed {
        logic run;
        logic ptr;
    } ctl_s;

    // Direction of one instance.
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    function automatic logic [7:0] win_base(input bit is_rx);
        return is_rx ? 8'h30 : 8'h20;
    endfunction

    function automatic int run_pos(input bit is_rx);
        return is_rx ? 3 : 1;
    endfunction

    function automatic int ptr_pos(input bit is_rx);
        return run_pos(is_rx) - 1;
    endfunction

endpackage

// File: rtl/sp_regs.sv
module sp_regs
    import sp_pkg::*;
#(
    parameter bit IS_RX = 1'b0,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [7:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    input  logic          ptr,
    output logic [AW-1:0] reg_rdata,
    output logic [AW-1:0] base_addr,
    output logic [AW-1:0] page_len,
    output logic          run,
    output logic          start_req
);
    localparam logic [7:0] A_BASE = win_base(IS_RX) + OFS_BASE;
    localparam logic [7:0] A_LEN  = win_base(IS_RX) + OFS_LEN;
    localparam logic [7:0] A_CTL  = win_base(IS_RX) + OFS_CTL;
    localparam int RUN_B = run_pos(IS_RX);
    localparam int PTR_B = ptr_pos(IS_RX);

    logic [AW-1:0] base_q, len_q;
    logic          run_q;
    logic          wr_base, wr_len, wr_ctl;
    logic [AW-1:0] ctl_view;
    logic          unused_wlow;

    assign unused_wlow = ^reg_wdata[1:0];

    assign wr_base = reg_we && (reg_addr == A_BASE);
    assign wr_len  = reg_we && (reg_addr == A_LEN);
    assign wr_ctl  = reg_we && (reg_addr == A_CTL);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            len_q  <= '0;
            run_q  <= 1'b0;
        end else begin
            if (wr_base) base_q <= {reg_wdata[AW-1:2], 2'b00};
            if (wr_len)  len_q  <= {reg_wdata[AW-1:2], 2'b00};
            if (wr_ctl)  run_q  <= reg_wdata[RUN_B];
        end
    end

    // A rising run write restarts the page sequence.
    assign start_req = wr_ctl && reg_wdata[RUN_B] && !run_q;

    always_comb begin
        ctl_view        = '0;
        ctl_view[RUN_B] = run_q;
        ctl_view[PTR_B] = ptr;
    end

    always_comb begin
        unique case (reg_addr)
            A_BASE:  reg_rdata = base_q;
            A_LEN:   reg_rdata = len_q;
            A_CTL:   reg_rdata = ctl_view;
            default: reg_rdata = '0;
        endcase
    end

    assign base_addr = base_q;
    assign page_len  = len_q;
    assign run       = run_q;

endmodule

// File: rtl/sp_addr_gen.sv
module sp_addr_gen #(
    parameter int AW    = 32,
    parameter int STEP  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic          fire,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] page_len,
    output logic [AW-1:0] cur_addr,
    output logic          ptr,
    output logic          page_evt
);
    localparam logic [AW:0] STEP_W = (AW+1)'(STEP);

    logic [AW-1:0] ofs_q;
    logic          ptr_q;
    logic          evt_q;
    logic          page_end;

    assign page_end = ({1'b0, ofs_q} + STEP_W) >= {1'b0, page_len};

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
            ptr_q <= 1'b0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (start_req) begin
                ofs_q <= '0;
                ptr_q <= 1'b0;
            end else if (fire) begin
                if (page_end) begin
                    ofs_q <= '0;
                    ptr_q <= !ptr_q;
                    evt_q <= 1'b1;
                end else begin
                    ofs_q <= ofs_q + AW'(STEP);
                end
            end
        end
    end

    assign cur_addr = base_addr + (ptr_q ? page_len : '0) + ofs_q;
    assign ptr      = ptr_q;
    assign page_evt = evt_q;

endmodule

// File: rtl/sp_swap.sv
module sp_swap #(
    parameter int DW = 32
) (
    input  logic          en,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    localparam int LANES = DW / 8;

    logic [DW-1:0] rev;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign rev[i*8 +: 8] = d[(LANES-1-i)*8 +: 8];
    end

    assign q = en ? rev : d;

endmodule

// File: rtl/sp_lane.sv
module sp_lane #(
    parameter bit IS_RX = 1'b0,
    parameter int DW    = 32
) (
    input  logic          run,
    input  logic          swap_en,
    input  logic          strm_valid_i,
    input  logic [DW-1:0] strm_data_i,
    output logic          strm_ready_o,
    output logic          strm_valid_o,
    output logic [DW-1:0] strm_data_o,
    input  logic          strm_ready_i,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    output logic          fire
);
    logic [DW-1:0] sw_in, sw_out;

    sp_swap #(.DW(DW)) u_swap (
        .en (swap_en),
        .d  (sw_in),
        .q  (sw_out)
    );

    if (IS_RX) begin : g_rx
        logic unused_tx_side;
        assign unused_tx_side = ^{strm_ready_i, mem_rdata};
        assign sw_in        = strm_data_i;
        assign mem_req      = run && strm_valid_i;
        assign mem_we       = 1'b1;
        assign mem_wdata    = sw_out;
        assign strm_ready_o = mem_req && mem_gnt;
        assign strm_valid_o = 1'b0;
        assign strm_data_o  = '0;
    end else begin : g_tx
        logic unused_rx_side;
        assign unused_rx_side = ^{strm_valid_i, strm_data_i};
        assign sw_in        = mem_rdata;
        assign mem_req      = run && strm_ready_i;
        assign mem_we       = 1'b0;
        assign mem_wdata    = '0;
        assign strm_valid_o = mem_req && mem_gnt;
        assign strm_data_o  = sw_out;
        assign strm_ready_o = 1'b0;
    end

    assign fire = mem_req && mem_gnt;

endmodule

// File: rtl/sync_page_engine.sv
module sync_page_engine
    import sp_pkg::*;
#(
    parameter bit IS_RX = 1'b0,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [7:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          big_endian,
    input  logic          strm_valid_i,
    input  logic [DW-1:0] strm_data_i,
    output logic          strm_ready_o,
    output logic          strm_valid_o,
    output logic [DW-1:0] strm_data_o,
    input  logic          strm_ready_i,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    output logic          page_evt
);
    localparam int STEP = DW / 8;

    ctl_s          ctl;
    logic          start_req_w;
    logic          fire_w;
    logic [AW-1:0] base_w, len_w;

    sp_regs #(.IS_RX(IS_RX), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ptr       (ctl.ptr),
        .reg_rdata (reg_rdata),
        .base_addr (base_w),
        .page_len  (len_w),
        .run       (ctl.run),
        .start_req (start_req_w)
    );

    sp_addr_gen #(.AW(AW), .STEP(STEP)) u_agen (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req_w),
        .fire      (fire_w),
        .base_addr (base_w),
        .page_len  (len_w),
        .cur_addr  (mem_addr),
        .ptr       (ctl.ptr),
        .page_evt  (page_evt)
    );

    sp_lane #(.IS_RX(IS_RX), .DW(DW)) u_lane (
        .run          (ctl.run),
        .swap_en      (big_endian),
        .strm_valid_i (strm_valid_i),
        .strm_data_i  (strm_data_i),
        .strm_ready_o (strm_ready_o),
        .strm_valid_o (strm_valid_o),
        .strm_data_o  (strm_data_o),
        .strm_ready_i (strm_ready_i),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_wdata    (mem_wdata),
        .mem_gnt      (mem_gnt),
        .mem_rdata    (mem_rdata),
        .fire         (fire_w)
    );

endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          run,
    input logic          start_req,
    input logic          ptr,
    input logic          page_evt,
    input logic          fire,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr
);
    // R6: a stopped engine never asks for memory
    a_r6_no_req_stopped: assert property (@(posedge clk) disable iff (rst)
        !run |-> !mem_req);

    // R6: pointer holds while stopped and not being restarted
    a_r6_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run && !start_req) |=> $stable(ptr));

    // R3: a restart lands on page 0 with run set
    a_r3_restart_page0: assert property (@(posedge clk) disable iff (rst)
        start_req |=> (!ptr && run));

    // R5: every page event follows an accepted transfer and a pointer toggle
    a_r5_evt_after_fire: assert property (@(posedge clk) disable iff (rst)
        fire && !start_req |=> (page_evt || $stable(ptr)));

    a_r5_evt_toggles: assert property (@(posedge clk) disable iff (rst)
        page_evt |-> (ptr != $past(ptr)));

    // R4: request addresses stay quadlet aligned
    a_r4_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R7: a transfer needs both request and grant
    a_r7_fire_handshake: assert property (@(posedge clk) disable iff (rst)
        fire |-> (mem_req && mem_gnt));

endmodule

bind sync_page_engine sp_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (ctl.run),
    .start_req (start_req_w),
    .ptr       (ctl.ptr),
    .page_evt  (page_evt),
    .fire      (fire_w),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr)
);

// File: tb/sim_sync_page_engine.sv
module sim_sync_page_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic        big_endian = 1'b0;
    logic        strm_valid_i = 1'b0;
    logic [31:0] strm_data_i = '0;
    logic        strm_ready_i = 1'b0;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] rd0, rd1, sdo0, sdo1, ad0, ad1, wd0, wd1;
    logic        sro0, sro1, svo0, svo1, rq0, rq1, we0, we1, ev0, ev1;

    int nchk = 0;
    int nfail = 0;
    int sel = 0;
    int dcount = 0;
    logic [31:0] m_base, m_len, m_ofs;
    bit          m_ptr, m_run;

    always #10 clk = !clk;

    // u0 receive, u1 transmit
    sync_page_engine #(.IS_RX(1'b1)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd0), .big_endian(big_endian),
        .strm_valid_i(strm_valid_i), .strm_data_i(strm_data_i),
        .strm_ready_o(sro0), .strm_valid_o(svo0), .strm_data_o(sdo0),
        .strm_ready_i(strm_ready_i), .mem_req(rq0), .mem_we(we0),
        .mem_addr(ad0), .mem_wdata(wd0), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .page_evt(ev0));

    sync_page_engine #(.IS_RX(1'b0)) u1 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd1), .big_endian(big_endian),
        .strm_valid_i(strm_valid_i), .strm_data_i(strm_data_i),
        .strm_ready_o(sro1), .strm_valid_o(svo1), .strm_data_o(sdo1),
        .strm_ready_i(strm_ready_i), .mem_req(rq1), .mem_we(we1),
        .mem_addr(ad1), .mem_wdata(wd1), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .page_evt(ev1));

    function automatic logic [7:0] wbase();
        return (sel == 0) ? 8'h30 : 8'h20;
    endfunction
    function automatic logic [31:0] runmask();
        return (sel == 0) ? 32'h8 : 32'h2;
    endfunction
    function automatic logic [31:0] ptrmask();
        return (sel == 0) ? 32'h4 : 32'h1;
    endfunction
    function automatic logic [31:0] bswap(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input bit g, input bit go, input bit we,
                        input logic [7:0] wa, input logic [31:0] wd);
        logic [31:0] d, ed, eaddr, ectl;
        bit ereq, fire, eevt, nr;
        @(negedge clk);
        d = {dcount[7:0], ~dcount[7:0], dcount[7:0] + 8'h3C, 8'hC3 ^ dcount[7:0]};
        dcount++;
        mem_gnt = g; strm_valid_i = go; strm_ready_i = go;
        strm_data_i = d; mem_rdata = d;
        reg_we = we; reg_addr = we ? wa : wbase() + 8'h08; reg_wdata = wd;
        #2;
        ereq = m_run && go;
        check("R7 request", (sel == 0) ? {31'd0, rq0} : {31'd0, rq1}, {31'd0, ereq});
        if (ereq) begin
            eaddr = m_base + (m_ptr ? m_len : 32'd0) + m_ofs;
            ed = big_endian ? bswap(d) : d;
            check("R4 address", (sel == 0) ? ad0 : ad1, eaddr);
            if (sel == 0) begin
                check("R8 rx data", wd0, ed);
                check("R7 rx write", {31'd0, we0}, 32'd1);
                check("R7 rx ready", {31'd0, sro0}, {31'd0, g});
            end else begin
                check("R7 tx read", {31'd0, we1}, 32'd0);
                check("R7 tx valid", {31'd0, svo1}, {31'd0, g});
                if (g) check("R8 tx data", sdo1, ed);
            end
        end
        fire = ereq && g;
        @(posedge clk);
        #1;
        eevt = 1'b0;
        if (fire) begin
            if (m_ofs + 32'd4 >= m_len) begin
                m_ofs = 0; m_ptr = !m_ptr; eevt = 1'b1;
            end else begin
                m_ofs = m_ofs + 32'd4;
            end
        end
        if (we) begin
            if (wa == wbase()) m_base = wd & ~32'h3;
            if (wa == wbase() + 8'h04) m_len = wd & ~32'h3;
            if (wa == wbase() + 8'h08) begin
                nr = |(wd & runmask());
                if (nr && !m_run) begin m_ptr = 1'b0; m_ofs = 0; end
                m_run = nr;
            end
        end
        reg_we = 1'b0; reg_addr = wbase() + 8'h08;
        #1;
        ectl = (m_run ? runmask() : 32'd0) | (m_ptr ? ptrmask() : 32'd0);
        check("R5 page event", (sel == 0) ? {31'd0, ev0} : {31'd0, ev1}, {31'd0, eevt});
        check("R2 control readback", (sel == 0) ? rd0 : rd1, ectl);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #2;
        check(tag, (sel == 0) ? rd0 : rd1, exp);
    endtask

    initial begin
        #4_000_000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int sizes[4];
        sizes[0] = 4; sizes[1] = 8; sizes[2] = 12; sizes[3] = 20;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state of both instances
        for (int s = 0; s < 2; s++) begin
            sel = s;
            rd(wbase(), 32'd0, "R1 base after reset");
            rd(wbase() + 8'h04, 32'd0, "R1 length after reset");
            rd(wbase() + 8'h08, 32'd0, "R1 control after reset");
            rd(8'h2C, 32'd0, "R2 unmapped offset");
            check("R1 no request", (s == 0) ? {31'd0, rq0} : {31'd0, rq1}, 32'd0);
            check("R1 no event", (s == 0) ? {31'd0, ev0} : {31'd0, ev1}, 32'd0);
        end
        m_base = 0; m_len = 0; m_ofs = 0; m_ptr = 0; m_run = 0;
        for (int s = 0; s < 2; s++) begin
            sel = s;
            m_base = 0; m_len = 0; m_ofs = 0; m_ptr = 0; m_run = 0;
            for (int z = 0; z < 4; z++) begin
                for (int b = 0; b < 2; b++) begin
                    logic [31:0] rawb;
                    int q;
                    big_endian = b[0];
                    q = sizes[z] / 4;
                    rawb = 32'h0000_1003 + s * 32'h400 + sizes[z] * 32'h40;
                    step(1'b0, 1'b0, 1'b1, wbase(), rawb);
                    step(1'b0, 1'b0, 1'b1, wbase() + 8'h04, sizes[z] | 32'h1);
                    rd(wbase(), rawb & ~32'h3, "R2 base masked");
                    rd(wbase() + 8'h04, sizes[z], "R2 length masked");
                    // R3 start from stopped
                    step(1'b0, 1'b0, 1'b1, wbase() + 8'h08, runmask());
                    for (int k = 0; k < 3 * q + 4; k++) begin
                        if (k == 2)  // R10 re-write run=1, pointer bit set
                            step(1'b1, 1'b1, 1'b1, wbase() + 8'h08, runmask() | ptrmask());
                        else
                            step((k % 3) != 2, (k % 5) != 4, 1'b0, 8'h00, 32'd0);
                    end
                    // R9 stop collides with a granted transfer
                    step(1'b1, 1'b1, 1'b1, wbase() + 8'h08, 32'd0);
                    // R6 stopped: no requests, pointer holds
                    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b0, 8'h00, 32'd0);
                    // R3 restart returns to page 0 base
                    step(1'b0, 1'b0, 1'b1, wbase() + 8'h08, runmask());
                    step(1'b1, 1'b1, 1'b0, 8'h00, 32'd0);
                    step(1'b0, 1'b0, 1'b1, wbase() + 8'h08, 32'd0);
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule